// File: doc/BRIEF.md
# A/D conversion control sequencer

This block is the digital half of a multi-channel successive-approximation A/D converter. Software programs it through a small synchronous register port. A control word selects the conversion length and starts or stops the converter. A status word holds the end-of-conversion flag, the interrupt enable, the single/scan mode bit and the channel selection. The analog front end sits outside the block. The block tells it which channel to sample through `conv_ch` and takes the finished result as a plain word on `sample_in`.

A cycle counter times each conversion. It runs 266 cycles in the slow setting and 134 cycles in the fast setting. When a conversion ends, the sample is stored in that channel's data register. In single mode the start bit then drops by itself. In scan mode the block walks a group of channels in ascending order and repeats the group until software clears the start bit.

The sequencer has three states. IDLE waits for a start write. CONV counts the conversion. STORE latches the sample and decides what comes next. The transitions are as follows:
- IDLE to CONV when start is written.
- CONV to CONV while the count has not reached its end.
- CONV to STORE on the last count.
- STORE to CONV when scanning continues.
- STORE to IDLE when a single conversion ends.
- CONV or STORE to IDLE when an abort is written.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x001F, the status word (address 1) reads 0x0000, every data register reads 0 and `irq` is 0.
- R2: Control bit 6 selects the conversion length. With bit 6 at 0 the sample is stored 266 cycles after the clock edge that accepts the start write. With bit 6 at 1 the sample is stored 134 cycles after that edge. One cycle earlier the data register still holds its old value.
- R3: Writing 1 to control bit 5 while it is 0 starts a conversion. In single mode (status bit 5 = 0) the block converts the channel in status bits 2:0, and control bit 5 clears on the same edge that stores the sample.
- R4: In scan mode (status bit 5 = 1) the block converts channels from the group base up to the selected channel, in ascending order. The group base is the selection with its two low bits cleared. After the last channel the block starts again at the base, and control bit 5 stays 1.
- R5: The end flag (status bit 7) sets when a single conversion completes. In scan mode it sets when the last channel of the group completes. It stays 0 while a group is only partly done.
- R6: The end flag clears only on a write to the status word with bit 7 at 0 that follows a read of the status word which returned bit 7 at 1. A write without such a read leaves the flag set.
- R7: `irq` is 1 exactly while the end flag and the interrupt enable (status bit 6) are both 1.
- R8: While control bit 5 is 1, writes to status bits 6, 5 and 2:0 and to control bit 6 are ignored.
- R9: Control bits 4:0 always read as 1, whatever value is written to them.
- R10: The data register for channel c is at address 2+c. It returns the 10-bit sample in bits 15:6 with bits 5:0 at 0. A conversion changes only the register of the channel it converted.
- R11: Writing 0 to control bit 5 during a conversion returns the block to idle at once. The data register of that channel is left unchanged and the end flag is not set.
- R12: `conv_ch` shows the channel being converted for the whole duration of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| sample_in | input | 10 | Converted sample from the analog front end |
| conv_ch | output | 3 | Channel currently being converted |
| irq | output | 1 | Interrupt request |

## Verification
The bench samples the data register one cycle before and exactly on the storing edge, at both conversion lengths and for every channel. A counter that is off by one, or that ignores the length select, would show the new value early or late. It sweeps every scan selection over two passes and checks the group base, the ascending order, the restart and the flag timing. A design that masked the base wrongly, skipped the wrap-around, or raised the flag on every channel would store the wrong registers or flag a partial group. It also tries to clear the flag without the prior read, rewrites the configuration during a scan, and aborts a conversion halfway. A faulty design would drop the flag, let the configuration change under a running scan, or store a sample from the aborted conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_STORE = 2'd2
    } seq_state_e;

    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_STAT  = 1;
    localparam int unsigned ADDR_DATA0 = 2;

    localparam int unsigned CTRL_FAST_BIT = 6;
    localparam int unsigned CTRL_RUN_BIT  = 5;
    localparam int unsigned RSVD_W        = 5;

    localparam int unsigned STAT_FLAG_BIT = 7;
    localparam int unsigned STAT_IE_BIT   = 6;
    localparam int unsigned STAT_SCAN_BIT = 5;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int unsigned CHW    = 3,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        wbyte,
    input  logic              seq_clear_run,
    input  logic              seq_set_flag,
    output logic              run_q,
    output logic              fast_q,
    output logic              scan_q,
    output logic              ie_q,
    output logic [CHW-1:0]    sel_q,
    output logic              flag_q,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] stat_word
);

    logic wr_ctrl, wr_stat, rd_stat;
    logic armed_q;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));
    assign rd_stat = bus_sel && !bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));

    assign start_pulse = wr_ctrl && wbyte[CTRL_RUN_BIT] && !run_q;
    assign stop_pulse  = wr_ctrl && !wbyte[CTRL_RUN_BIT] && run_q;

    // start/stop bit: software sets and clears, sequencer clears in single mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (start_pulse) begin
            run_q <= 1'b1;
        end else if (stop_pulse || seq_clear_run) begin
            run_q <= 1'b0;
        end
    end

    // configuration: frozen while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            ie_q   <= 1'b0;
            scan_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (wr_ctrl && !run_q) begin
                fast_q <= wbyte[CTRL_FAST_BIT];
            end
            if (wr_stat && !run_q) begin
                ie_q   <= wbyte[STAT_IE_BIT];
                scan_q <= wbyte[STAT_SCAN_BIT];
                sel_q  <= wbyte[CHW-1:0];
            end
        end
    end

    // end flag: read-as-one then write-zero clear; a new set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (seq_set_flag) begin
                flag_q <= 1'b1;
            end else if (wr_stat && armed_q && !wbyte[STAT_FLAG_BIT]) begin
                flag_q <= 1'b0;
            end
            if (wr_stat) begin
                armed_q <= 1'b0;
            end else if (rd_stat && flag_q) begin
                armed_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[RSVD_W-1:0]    = '1;
        ctrl_word[CTRL_FAST_BIT] = fast_q;
        ctrl_word[CTRL_RUN_BIT]  = run_q;
    end

    always_comb begin
        stat_word                = '0;
        stat_word[CHW-1:0]       = sel_q;
        stat_word[STAT_SCAN_BIT] = scan_q;
        stat_word[STAT_IE_BIT]   = ie_q;
        stat_word[STAT_FLAG_BIT] = flag_q;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned CHW      = 3,
    parameter int unsigned GRP      = 4,
    parameter int unsigned SLOW_CYC = 266,
    parameter int unsigned FAST_CYC = 134,
    localparam int unsigned MAXC    = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC,
    localparam int unsigned CNT_W   = $clog2(MAXC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pulse,
    input  logic             stop_pulse,
    input  logic             fast,
    input  logic             scan,
    input  logic [CHW-1:0]   sel,
    output logic [CHW-1:0]   conv_ch,
    output logic             store_pulse,
    output logic             set_flag,
    output logic             clear_run,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CHW-1:0] BASE_MASK = ~CHW'(GRP - 1);

    seq_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CHW-1:0]   ch_q, ch_n;
    logic [CNT_W-1:0] end_cnt;
    logic [CHW-1:0]   base_ch;
    logic             last_ch;

    assign end_cnt = fast ? CNT_W'(FAST_CYC - 2) : CNT_W'(SLOW_CYC - 2);
    assign base_ch = sel & BASE_MASK;
    assign last_ch = (ch_q == sel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            ch_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            ch_q  <= ch_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        ch_n  = ch_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_pulse) begin
                    st_n  = ST_CONV;
                    cnt_n = '0;
                    ch_n  = scan ? base_ch : sel;
                end
            end
            ST_CONV: begin
                if (stop_pulse) begin
                    st_n = ST_IDLE;
                end else if (cnt_q == end_cnt) begin
                    st_n = ST_STORE;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_STORE: begin
                if (stop_pulse || !scan) begin
                    st_n = ST_IDLE;
                end else begin
                    st_n  = ST_CONV;
                    cnt_n = '0;
                    ch_n  = last_ch ? base_ch : ch_q + 1'b1;
                end
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        store_pulse = (st_q == ST_STORE) && !stop_pulse;
        set_flag    = store_pulse && (!scan || last_ch);
        clear_run   = store_pulse && !scan;
    end

    assign conv_ch = ch_q;
    assign state_o = st_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
    parameter int unsigned NCH      = 8,
    parameter int unsigned CHW      = 3,
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                store_pulse,
    input  logic [CHW-1:0]      store_ch,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CHW-1:0]      rd_idx,
    output logic [DATA_W-1:0]   rd_word
);

    logic [SAMPLE_W-1:0] slot_words [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_slot
        logic [SAMPLE_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (store_pulse && (store_ch == CHW'(k))) begin
                slot_q <= sample;
            end
        end
        assign slot_words[k] = slot_q;
    end

    assign rd_word = {slot_words[rd_idx], {(DATA_W - SAMPLE_W){1'b0}}};

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter int unsigned GRP      = 4,
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned SLOW_CYC = 266,
    parameter int unsigned FAST_CYC = 134,
    localparam int unsigned CHW     = $clog2(NCH),
    localparam int unsigned MAXC    = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC,
    localparam int unsigned CNT_W   = $clog2(MAXC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [CHW-1:0]      conv_ch,
    output logic                irq
);

    logic             run_q, fast_q, scan_q, ie_q, flag_q;
    logic [CHW-1:0]   sel_q;
    logic             start_pulse, stop_pulse;
    logic             store_pulse, set_flag, clear_run;
    seq_state_e       seq_state;
    logic [CNT_W-1:0] seq_cnt;
    logic [DATA_W-1:0] ctrl_word, stat_word, data_word;
    logic [CHW-1:0]   data_idx;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:8];

    adc_seq_regs #(
        .CHW    (CHW),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .wbyte         (bus_wdata[7:0]),
        .seq_clear_run (clear_run),
        .seq_set_flag  (set_flag),
        .run_q         (run_q),
        .fast_q        (fast_q),
        .scan_q        (scan_q),
        .ie_q          (ie_q),
        .sel_q         (sel_q),
        .flag_q        (flag_q),
        .start_pulse   (start_pulse),
        .stop_pulse    (stop_pulse),
        .ctrl_word     (ctrl_word),
        .stat_word     (stat_word)
    );

    adc_seq_fsm #(
        .CHW      (CHW),
        .GRP      (GRP),
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .fast        (fast_q),
        .scan        (scan_q),
        .sel         (sel_q),
        .conv_ch     (conv_ch),
        .store_pulse (store_pulse),
        .set_flag    (set_flag),
        .clear_run   (clear_run),
        .state_o     (seq_state),
        .cnt_o       (seq_cnt)
    );

    assign data_idx = CHW'(bus_addr - ADDR_W'(ADDR_DATA0));

    adc_seq_store #(
        .NCH      (NCH),
        .CHW      (CHW),
        .SAMPLE_W (SAMPLE_W),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_pulse (store_pulse),
        .store_ch    (conv_ch),
        .sample      (sample_in),
        .rd_idx      (data_idx),
        .rd_word     (data_word)
    );

    always_comb begin
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata = ctrl_word;
        end else if (bus_addr == ADDR_W'(ADDR_STAT)) begin
            bus_rdata = stat_word;
        end else if (bus_addr >= ADDR_W'(ADDR_DATA0) &&
                     bus_addr <  ADDR_W'(ADDR_DATA0 + NCH)) begin
            bus_rdata = data_word;
        end else begin
            bus_rdata = '0;
        end
    end

    assign irq = flag_q & ie_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int unsigned CHW      = 3,
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned SLOW_CYC = 266,
    parameter int unsigned FAST_CYC = 134
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic             fast_q,
    input logic             scan_q,
    input logic             ie_q,
    input logic [CHW-1:0]   sel_q,
    input logic             flag_q,
    input logic             irq,
    input logic             store_pulse,
    input logic             stop_pulse,
    input seq_state_e       seq_state,
    input logic [CNT_W-1:0] seq_cnt
);

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_CONV) |->
            (seq_cnt <= (fast_q ? CNT_W'(FAST_CYC - 2) : CNT_W'(SLOW_CYC - 2))));

    a_r3_single_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (store_pulse && !scan_q) |=> !run_q);

    a_r4_scan_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (store_pulse && scan_q) |=> run_q);

    a_r5_flag_from_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(store_pulse));

    a_r7_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(flag_q) || $rose(ie_q)));

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |->
            ($stable(sel_q) && $stable(scan_q) && $stable(ie_q) && $stable(fast_q)));

    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> ((seq_state == ST_IDLE) && !$rose(flag_q)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .CHW      (CHW),
    .CNT_W    (CNT_W),
    .SLOW_CYC (SLOW_CYC),
    .FAST_CYC (FAST_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_q       (run_q),
    .fast_q      (fast_q),
    .scan_q      (scan_q),
    .ie_q        (ie_q),
    .sel_q       (sel_q),
    .flag_q      (flag_q),
    .irq         (irq),
    .store_pulse (store_pulse),
    .stop_pulse  (stop_pulse),
    .seq_state   (seq_state),
    .seq_cnt     (seq_cnt)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    localparam int SLOW = 266;
    localparam int FAST = 134;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [9:0]  sample_in;
    logic [2:0]  conv_ch;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tag = 0;
    logic [15:0] expd [8];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign sample_in = 10'(int'(conv_ch) * 37 + tag * 11 + 5);

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sample_in (sample_in),
        .conv_ch   (conv_ch),
        .irq       (irq)
    );

    function automatic logic [15:0] expw(input int c, input int t);
        logic [9:0] s;
        s = 10'(c * 37 + t * 11 + 5);
        return {s, 6'b0};
    endfunction

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // combinational look without an edge: no read side effect
    task automatic peek(input logic [3:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // real read across an edge: arms the flag clear
    task automatic bus_read(input logic [3:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic check_all_data(input string what);
        logic [15:0] v;
        for (int c = 0; c < 8; c++) begin
            peek(4'(2 + c), v);
            check(what, v, expd[c]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int st, n, base, g, c;
        for (int i = 0; i < 8; i++) expd[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(4'd0, v); check("R1 ctrl reset", v, 16'h001F);
        peek(4'd1, v); check("R1 stat reset", v, 16'h0000);
        check("R1 irq reset", {15'b0, irq}, 16'h0000);
        check_all_data("R1 data reset");

        // R9 reserved bits read 1 whatever is written
        bus_write(4'd0, 16'h0000);
        @(negedge clk); peek(4'd0, v); check("R9 reserved read 1", v, 16'h001F);

        // single mode sweep: both lengths, all channels
        for (int f = 0; f < 2; f++) begin
            for (int ch = 0; ch < 8; ch++) begin
                n = f ? FAST : SLOW;
                tag = f * 8 + ch + 1;
                bus_write(4'd1, 16'h0040 | 16'(ch));
                bus_write(4'd0, (f ? 16'h0040 : 16'h0000) | 16'h0020 | 16'h0000);
                st = cyc;
                wait_to(st + n - 1);
                peek(4'(2 + ch), v); check("R2 data not yet stored", v, expd[ch]);
                check("R12 conv_ch during conversion", 16'(conv_ch), 16'(ch));
                peek(4'd0, v); check("R3 run set while converting", v,
                                     (f ? 16'h0040 : 16'h0000) | 16'h003F);
                wait_to(st + n);
                expd[ch] = expw(ch, tag);
                check_all_data("R2 R10 data after single");
                peek(4'd0, v); check("R3 run self clear", v,
                                     (f ? 16'h0040 : 16'h0000) | 16'h001F);
                peek(4'd1, v); check("R5 flag after single", v, 16'h00C0 | 16'(ch));
                check("R7 irq with flag and enable", {15'b0, irq}, 16'h0001);
                if (f == 0 && ch == 0) begin
                    bus_write(4'd1, 16'h0040);
                    @(negedge clk); peek(4'd1, v);
                    check("R6 no clear without read", v, 16'h00C0);
                end
                bus_read(4'd1);
                bus_write(4'd1, 16'h0040 | 16'(ch));
                @(negedge clk); peek(4'd1, v);
                check("R6 flag cleared", v, 16'h0040 | 16'(ch));
                check("R7 irq drops", {15'b0, irq}, 16'h0000);
            end
        end

        // scan mode sweep over every selection, two passes each
        for (int s = 0; s < 8; s++) begin
            int fs;
            fs = s % 2;
            n = fs ? FAST : SLOW;
            base = s & ~3;
            g = s - base + 1;
            tag = 40 + s;
            bus_write(4'd1, 16'h0060 | 16'(s));
            bus_write(4'd0, (fs ? 16'h0040 : 16'h0000) | 16'h003F);
            st = cyc;
            if (s == 5) begin
                // R8 config writes ignored while running
                bus_write(4'd1, 16'h0000);
                bus_write(4'd0, (fs ? 16'h0000 : 16'h0040) | 16'h003F);
                @(negedge clk);
                peek(4'd1, v); check("R8 stat write ignored", v, 16'h0060 | 16'(s));
                peek(4'd0, v); check("R8 clock select write ignored", v,
                                     (fs ? 16'h0040 : 16'h0000) | 16'h003F);
            end
            for (int j = 1; j <= 2 * g; j++) begin
                wait_to(st + j * n);
                c = base + ((j - 1) % g);
                expd[c] = expw(c, tag);
                check_all_data("R4 R10 scan data");
                peek(4'd0, v); check("R4 run stays in scan", v,
                                     (fs ? 16'h0040 : 16'h0000) | 16'h003F);
                peek(4'd1, v);
                check("R5 scan flag", v,
                      (j >= g ? 16'h00E0 : 16'h0060) | 16'(s));
                if (j == g) tag = 80 + s;
            end
            bus_write(4'd0, (fs ? 16'h0040 : 16'h0000) | 16'h001F);
            @(negedge clk);
            peek(4'd0, v); check("R4 scan stopped by write", v,
                                 (fs ? 16'h0040 : 16'h0000) | 16'h001F);
            bus_read(4'd1);
            bus_write(4'd1, 16'h0060 | 16'(s));
            @(negedge clk); peek(4'd1, v);
            check("R6 flag cleared after scan", v, 16'h0060 | 16'(s));
        end

        // R11 abort mid-conversion
        tag = 99;
        bus_write(4'd1, 16'h0042);
        bus_write(4'd0, 16'h003F);
        st = cyc;
        wait_to(st + 100);
        bus_write(4'd0, 16'h001F);
        @(negedge clk);
        peek(4'd0, v); check("R11 run cleared by abort", v, 16'h001F);
        wait_to(st + 400);
        check_all_data("R11 data unchanged after abort");
        peek(4'd1, v); check("R11 no flag after abort", v, 16'h0042);
        check("R11 no irq after abort", {15'b0, irq}, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule